// File: doc/BRIEF.md
# Write-Once Flash Clock Divider

This block holds the single configuration byte that sets the timing tick of a nonvolatile-memory controller. It also produces that tick. Software writes the byte over a plain register interface: a select, a write strobe, write data and read data. Only the first write after reset is taken. That write stores a divisor and a prescale choice. Whatever the data, it also sets a sticky loaded flag. The loaded flag drives the enable that allows erase and program operations.

The tick is a one-bus-cycle enable pulse, not a derived clock, so the whole block runs in the bus clock domain. A fixed divide-by-8 stage can be placed ahead of the main divider. The main divider divides by the divisor field plus one. Downstream erase and program logic counts whole tick periods. Both counters stay at zero until the loaded flag is set. They restart on the cycle the first write is accepted.

A two-state machine controls the register:

- `CFG_BLANK` is entered on reset.
- The transition `BLANK_TO_LOCKED` is taken on the first accepted write, which is select and write strobe high together.
- The hold transition `LOCKED_HOLD` keeps the machine in `CFG_LOCKED` until the next reset.

Top module: `nvm_tick_divider`

## Requirements
- R1: After reset, a read with select high returns 0x00, `pe_enable` is 0 and `nvm_tick` is 0.
- R2: The first write after reset stores write-data bits 6:0. From the next cycle on, a read returns bit 7 = 1 and those stored bits, for any data, including 0x00. Write-data bit 7 is never stored.
- R3: Every write after the first leaves the stored bits 6:0 unchanged, including a write that lands on a tick cycle.
- R4: `pe_enable` is 0 while the loaded flag (read bit 7) is 0 and 1 once it is set, and it stays 1 until reset.
- R5: `nvm_tick` is never high while the loaded flag is clear.
- R6: With bit 6 = 0, `nvm_tick` is high for one bus cycle every DIV+1 cycles, where DIV is bits 5:0. With DIV = 0 the tick is high every cycle.
- R7: With bit 6 = 1, the tick period is 8 × (DIV+1) bus cycles.
- R8: Count the first bus cycle after the clock edge that accepts the first write as cycle 0. The first tick is high in cycle N-1, where N is the tick period.
- R9: While select is low, read data is 0x00.
- R10: A write strobe with select low is ignored. It neither stores data nor sets the loaded flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, acts only with select |
| reg_wdata | input | 8 | Write data: bit 6 prescale, bits 5:0 divisor, bit 7 ignored |
| reg_rdata | output | 8 | Read data: bit 7 loaded flag, 6:0 stored bits; zero when not selected |
| pe_enable | output | 1 | Erase/program permitted |
| nvm_tick | output | 1 | One-cycle timing tick at the divided rate |

## Verification
A write to the locked register and a divider tick can fall in the same bus cycle. The write logic must then leave the divisor alone, and the counters must keep running undisturbed. The bench provokes this case directly. It waits until the tick is seen high and then drives a write of different data in that very cycle. It judges the result from the read-back value and from the next tick, which must arrive exactly one period later. The first accepted write and the counter restart also share a cycle. The tick position measured from that write edge is checked against the formula for every configuration in the table.

// File: rtl/nvmdiv_pkg.sv
package nvmdiv_pkg;

    // Lock state of the configuration register
    typedef enum logic {
        CFG_BLANK  = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_e;

endpackage

// File: rtl/nvmdiv_cfg_reg.sv
module nvmdiv_cfg_reg
    import nvmdiv_pkg::*;
#(
    parameter  int DIV_W  = 6,
    localparam int CFG_W  = DIV_W + 1,
    localparam int DATA_W = DIV_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CFG_W-1:0]  cfg_bits,
    output logic              loaded,
    output logic              load_pulse
);

    cfg_state_e state_q, state_d;
    logic       accept;
    logic       unused_wr_flag;

    assign accept         = sel & wr;
    assign unused_wr_flag = wdata[DATA_W-1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CFG_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_BLANK:  if (accept) state_d = CFG_LOCKED;   // BLANK_TO_LOCKED
            CFG_LOCKED: state_d = CFG_LOCKED;               // LOCKED_HOLD
            default:    state_d = CFG_BLANK;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        loaded     = 1'b0;
        load_pulse = 1'b0;
        unique case (state_q)
            CFG_BLANK: begin
                loaded     = 1'b0;
                load_pulse = accept;
            end
            CFG_LOCKED: begin
                loaded     = 1'b1;
                load_pulse = 1'b0;
            end
            default: begin
                loaded     = 1'b0;
                load_pulse = 1'b0;
            end
        endcase
    end

    // Stored prescale select and divisor, captured only once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_bits <= '0;
        end else if (load_pulse) begin
            cfg_bits <= wdata[CFG_W-1:0];
        end
    end

    assign rdata = sel ? {loaded, cfg_bits} : '0;

endmodule

// File: rtl/nvmdiv_prescaler.sv
module nvmdiv_prescaler #(
    parameter  int PRE_RATIO = 8,
    localparam int PRE_W     = $clog2(PRE_RATIO)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic use_pre,
    output logic stage_hit
);

    generate
        if (PRE_W == 0) begin : g_no_pre
            assign stage_hit = run;
        end else begin : g_pre
            localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_RATIO - 1);
            logic [PRE_W-1:0] pre_cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    pre_cnt <= '0;
                end else if (run && use_pre) begin
                    pre_cnt <= (pre_cnt == LAST) ? '0 : pre_cnt + 1'b1;
                end
            end

            assign stage_hit = run && (!use_pre || (pre_cnt == LAST));
        end
    endgenerate

endmodule

// File: rtl/nvmdiv_divider.sv
module nvmdiv_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             advance,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    logic [DIV_W-1:0] div_cnt;
    logic             at_limit;

    assign at_limit = (div_cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            div_cnt <= '0;
        end else if (run && advance) begin
            div_cnt <= at_limit ? '0 : div_cnt + 1'b1;
        end
    end

    assign tick = run && advance && at_limit;

endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider #(
    parameter  int DIV_W     = 6,
    parameter  int PRE_RATIO = 8,
    localparam int CFG_W     = DIV_W + 1,
    localparam int DATA_W    = DIV_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pe_enable,
    output logic              nvm_tick
);

    logic [CFG_W-1:0] cfg_bits;
    logic             loaded;
    logic             load_pulse;
    logic             stage_hit;

    nvmdiv_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (reg_sel),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .cfg_bits   (cfg_bits),
        .loaded     (loaded),
        .load_pulse (load_pulse)
    );

    nvmdiv_prescaler #(.PRE_RATIO(PRE_RATIO)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load_pulse),
        .run       (loaded),
        .use_pre   (cfg_bits[DIV_W]),
        .stage_hit (stage_hit)
    );

    nvmdiv_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load_pulse),
        .run     (loaded),
        .advance (stage_hit),
        .limit   (cfg_bits[DIV_W-1:0]),
        .tick    (nvm_tick)
    );

    assign pe_enable = loaded;

endmodule

// File: rtl/nvmdiv_checker.sv
module nvmdiv_checker #(
    parameter  int DIV_W     = 6,
    parameter  int PRE_RATIO = 8,
    localparam int CFG_W     = DIV_W + 1,
    localparam int DATA_W    = DIV_W + 2,
    localparam int PRE_W     = $clog2(PRE_RATIO),
    localparam int GAP_W     = DIV_W + 1 + PRE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [CFG_W-1:0]  wr_bits,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [CFG_W-1:0]  cfg_bits,
    input logic              pe_enable,
    input logic              nvm_tick
);

    logic [GAP_W-1:0] base_len;
    logic [GAP_W-1:0] period_m1;
    logic [GAP_W-1:0] gap;

    assign base_len  = GAP_W'(cfg_bits[DIV_W-1:0]) + GAP_W'(1);
    assign period_m1 = (cfg_bits[DIV_W] ? (base_len << PRE_W) : base_len) - GAP_W'(1);

    // Cycles since the load edge or the last tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (!pe_enable || nvm_tick) begin
            gap <= '0;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    p_idle_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_enable |-> !nvm_tick);

    p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pe_enable |=> pe_enable);

    p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pe_enable && reg_sel && reg_wr) |=> (pe_enable && cfg_bits == $past(wr_bits)));

    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pe_enable |=> $stable(cfg_bits));

    p_no_stray_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pe_enable && !reg_sel) |=> !pe_enable);

    p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_tick |-> (gap == period_m1));

    p_tick_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_enable && gap == period_m1) |-> nvm_tick);

    p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata == '0));

endmodule

bind nvm_tick_divider nvmdiv_checker #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .wr_bits   (reg_wdata[DIV_W:0]),
    .reg_rdata (reg_rdata),
    .cfg_bits  (cfg_bits),
    .pe_enable (pe_enable),
    .nvm_tick  (nvm_tick)
);

// File: tb/tb_nvm_tick_divider.sv
module tb_nvm_tick_divider;

    localparam int NVEC = 8;
    localparam logic [7:0] VEC_CFG [NVEC] = '{8'h00, 8'h05, 8'h3F, 8'h40, 8'h43, 8'hBF, 8'h7F, 8'hC2};
    localparam int         VEC_PER [NVEC] = '{1, 6, 64, 8, 32, 64, 512, 24};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pe_enable;
    logic       nvm_tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nvm_tick_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pe_enable (pe_enable),
        .nvm_tick  (nvm_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Returns at the negedge of cycle 0 after the accepting edge
    task automatic do_write(input logic [7:0] d, input logic s);
        @(negedge clk);
        reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic read_reg(output int v);
        reg_sel = 1'b1;
        #1;
        v = int'(reg_rdata);
        reg_sel = 1'b0;
        #1;
    endtask

    // Counts negedges until the tick is seen high
    task automatic count_to_tick(output int n);
        n = 0;
        while (!nvm_tick && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int v, n, seen;
        do_reset();

        // Table of configurations and expected periods
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            read_reg(v);
            chk("R1 reset readback", v, 0);
            chk("R1 reset enable", int'(pe_enable), 0);
            seen = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (nvm_tick) seen++;
            end
            chk("R5 no tick before load", seen, 0);
            do_write(VEC_CFG[i], 1'b1);
            read_reg(v);
            chk("R2 first write readback", v, int'({1'b1, VEC_CFG[i][6:0]}));
            chk("R4 enable after load", int'(pe_enable), 1);
            count_to_tick(n);
            chk("R8 first tick position", n, VEC_PER[i] - 1);
            @(negedge clk);
            if (VEC_PER[i] > 1) chk("R6 tick width", int'(nvm_tick), 0);
            count_to_tick(n);
            chk(VEC_CFG[i][6] ? "R7 prescaled period" : "R6 period", n + 1, VEC_PER[i]);
        end

        // R10: strobe without select, then an all-zero first write (R2)
        do_reset();
        do_write(8'h45, 1'b0);
        chk("R10 enable after unselected write", int'(pe_enable), 0);
        read_reg(v);
        chk("R10 readback after unselected write", v, 0);
        do_write(8'h00, 1'b1);
        read_reg(v);
        chk("R2 zero data still loads", v, 8'h80);
        chk("R4 enable after zero write", int'(pe_enable), 1);
        #1;
        chk("R9 unselected read is zero", int'(reg_rdata), 0);

        // R3: locked write coincident with a tick
        do_reset();
        do_write(8'h02, 1'b1);
        count_to_tick(n);
        chk("R8 first tick div3", n, 2);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h55;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
        count_to_tick(n);
        chk("R3 tick period kept after locked write", n + 1, 3);
        read_reg(v);
        chk("R3 value kept after locked write", v, 8'h82);
        do_write(8'hFF, 1'b1);
        read_reg(v);
        chk("R3 second write ignored", v, 8'h82);
        chk("R4 enable stays set", int'(pe_enable), 1);

        // R1: reset during operation, then a new first write
        do_reset();
        read_reg(v);
        chk("R1 readback after re-reset", v, 0);
        chk("R1 tick after re-reset", int'(nvm_tick), 0);
        do_write(8'h41, 1'b1);
        read_reg(v);
        chk("R2 reload after reset", v, 8'hC1);
        count_to_tick(n);
        chk("R8 first tick prescale div2", n, 15);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule